// File: doc/BRIEF.md
# Segment Write Guard

This block sits between the CPU's memory write request and the memory write strobe. The physical space is 4 MB, split into 64 segments of 64 KB each. Every write is checked against a protect setting for the segment it addresses. The lookup is combinational, so it adds no wait cycles. A write that lands in a protected segment never reaches memory.

The protect setting comes from one of two sources:
- **Bitmap mode:** one bit per segment, so the protected segments can form any pattern.
- **Aligned-region mode:** a single aligned block of 2^k segments around a base segment.

The policy bit decides what happens to a blocked write:
- **Silent mode:** the write is simply dropped.
- **Trap mode:** the write is dropped, a sticky violation flag is set, and an interrupt request is raised. The flag remembers which segment was hit.

All register writes are accepted only while the supervisor input is high.

The reporter is a two-state machine:
- `RPT_IDLE` moves to `RPT_FLAGGED` on a trapped violation.
- `RPT_FLAGGED` moves back to `RPT_IDLE` on a supervisor write of 1 to the status flag bit, unless a new violation arrives in the same cycle.
- A violation that arrives while the machine is already flagged keeps it flagged.

Top module: `seg_write_guard`

## Requirements
- R1: After reset, every segment is writable, the control register reads 1 (trap policy, bitmap mode), the flag is clear and `irq` is 0.
- R2: The segment index is `cpu_addr[21:16]`. Bitmap word w sits at register address 4+w, and its bit b protects segment 32w+b (1 = protected). Any pattern of bits is honoured, contiguous or not.
- R3: In the same cycle, `mem_wr_en` follows `cpu_wr` for a writable segment and is 0 for a protected one, with no register in the path.
- R4: With control bit 0 cleared (silent policy), a blocked write leaves `irq` at 0 and leaves the status register unchanged.
- R5: With control bit 0 set (trap policy), a blocked write makes `irq` 1 from the next cycle. The status register (address 2) then reads bit 0 = 1 and bits 13:8 = the faulting segment.
- R6: The flag stays set, and keeps the segment it first recorded, until a supervisor writes status with bit 0 = 1; it is clear from the next cycle. Writing 0 has no effect. A violation in the same cycle as a clear wins and records its own segment.
- R7: With control bit 1 set, the bitmap is ignored and a segment is protected when its index equals the base segment (region register bits 5:0) in every bit at or above bit k (region register bits 10:8). A value of k of 6 or more protects the whole space.
- R8: A register write made while `supervisor` is 0 is ignored, including a flag clear.
- R9: `reg_rdata` shows the register at `reg_addr` combinationally; addresses 3 and unused table words read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| supervisor | input | 1 | Privileged-mode indication from the CPU |
| cpu_wr | input | 1 | CPU memory write request |
| cpu_addr | input | 22 | CPU physical byte address |
| mem_wr_en | output | 1 | Gated memory write strobe |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Write-violation interrupt request (level) |

## Verification
The gated strobe and the register read data are due in the same cycle the inputs change. The bench therefore checks them one time unit after driving, and before the next rising edge.

Register writes, the flag, the interrupt and the recorded segment appear only after the edge that captures the stimulus. Their checks are queued only after the driver task has crossed that edge.

The scoreboard receives each expected item when its result is due, and compares it immediately against the live outputs.

// File: rtl/segwp_pkg.sv
package segwp_pkg;
    typedef enum logic [0:0] {
        RPT_IDLE    = 1'b0,
        RPT_FLAGGED = 1'b1
    } rpt_state_e;

    localparam int unsigned REG_CTRL   = 0;
    localparam int unsigned REG_REGION = 1;
    localparam int unsigned REG_STATUS = 2;
    localparam int unsigned REG_TABLE0 = 4;
    localparam int unsigned FIELD_HI   = 8;
endpackage

// File: rtl/segwp_table.sv
module segwp_table #(
    parameter int IDX_W  = 6,
    parameter int DATA_W = 32,
    parameter int WSEL_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WSEL_W-1:0] wr_word,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [WSEL_W-1:0] rd_word,
    output logic [DATA_W-1:0] rd_data,
    input  logic [IDX_W-1:0]  idx,
    output logic              prot
);
    localparam int NSEG   = 1 << IDX_W;
    localparam int NWORDS = (NSEG + DATA_W - 1) / DATA_W;

    logic [DATA_W-1:0]        words [NWORDS];
    logic [NWORDS*DATA_W-1:0] bitmap;

    for (genvar w = 0; w < NWORDS; w++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                words[w] <= '0;
            else if (wr_en && wr_word == WSEL_W'(w))
                words[w] <= wr_data;
        end
        assign bitmap[w*DATA_W +: DATA_W] = words[w];
    end

    always_comb begin
        rd_data = '0;
        for (int w = 0; w < NWORDS; w++)
            if (rd_word == WSEL_W'(w))
                rd_data = words[w];
    end

    assign prot = bitmap[idx];
endmodule

// File: rtl/segwp_region.sv
module segwp_region #(
    parameter int IDX_W = 6,
    parameter int KW    = 3
) (
    input  logic [IDX_W-1:0] base,
    input  logic [KW-1:0]    k,
    input  logic [IDX_W-1:0] idx,
    output logic             hit
);
    logic [IDX_W-1:0] keep;

    always_comb begin
        for (int b = 0; b < IDX_W; b++)
            keep[b] = (KW'(b) >= k);
        hit = ((idx ^ base) & keep) == '0;
    end
endmodule

// File: rtl/segwp_report.sv
module segwp_report
    import segwp_pkg::*;
#(
    parameter int IDX_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             viol,
    input  logic [IDX_W-1:0] viol_idx,
    input  logic             clr,
    output logic             flag,
    output logic             irq,
    output logic [IDX_W-1:0] seg_rec
);
    rpt_state_e st_q, st_d;
    logic       capture;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= RPT_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RPT_IDLE:    if (viol)         st_d = RPT_FLAGGED;
            RPT_FLAGGED: if (clr && !viol) st_d = RPT_IDLE;
            default:                       st_d = RPT_IDLE;
        endcase
    end

    assign capture = viol && (st_q == RPT_IDLE || clr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       seg_rec <= '0;
        else if (capture) seg_rec <= viol_idx;
    end

    always_comb begin
        flag = (st_q == RPT_FLAGGED);
        irq  = flag;
    end
endmodule

// File: rtl/seg_write_guard.sv
module seg_write_guard
    import segwp_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int SEG_W  = 16,
    parameter int DATA_W = 32,
    parameter int REG_AW = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              supervisor,
    input  logic              cpu_wr,
    input  logic [ADDR_W-1:0] cpu_addr,
    output logic              mem_wr_en,
    input  logic              reg_we,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int IDX_W = ADDR_W - SEG_W;
    localparam int KW    = $clog2(IDX_W + 1);

    logic [IDX_W-1:0]  seg_idx;
    logic              trap_mode, mask_mode;
    logic [IDX_W-1:0]  base_q;
    logic [KW-1:0]     k_q;
    logic              tbl_prot, rgn_prot, seg_prot;
    logic              cfg_wr, tbl_wr, clr, viol, flag;
    logic [IDX_W-1:0]  seg_rec;
    logic [REG_AW-1:0] wsel;
    logic [DATA_W-1:0] tbl_rd;
    logic              unused_bits;

    assign seg_idx     = cpu_addr[ADDR_W-1 -: IDX_W];
    assign unused_bits = ^{cpu_addr[SEG_W-1:0], reg_wdata};

    assign cfg_wr = reg_we && supervisor;
    assign tbl_wr = cfg_wr && (reg_addr >= REG_AW'(REG_TABLE0));
    assign wsel   = reg_addr - REG_AW'(REG_TABLE0);
    assign clr    = cfg_wr && (reg_addr == REG_AW'(REG_STATUS)) && reg_wdata[0];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            trap_mode <= 1'b1;
            mask_mode <= 1'b0;
        end else if (cfg_wr && reg_addr == REG_AW'(REG_CTRL)) begin
            trap_mode <= reg_wdata[0];
            mask_mode <= reg_wdata[1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            base_q <= '0;
            k_q    <= '0;
        end else if (cfg_wr && reg_addr == REG_AW'(REG_REGION)) begin
            base_q <= reg_wdata[IDX_W-1:0];
            k_q    <= reg_wdata[FIELD_HI +: KW];
        end
    end

    segwp_table #(.IDX_W(IDX_W), .DATA_W(DATA_W), .WSEL_W(REG_AW)) u_table (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (tbl_wr),
        .wr_word (wsel),
        .wr_data (reg_wdata),
        .rd_word (wsel),
        .rd_data (tbl_rd),
        .idx     (seg_idx),
        .prot    (tbl_prot)
    );

    segwp_region #(.IDX_W(IDX_W), .KW(KW)) u_region (
        .base (base_q),
        .k    (k_q),
        .idx  (seg_idx),
        .hit  (rgn_prot)
    );

    assign seg_prot  = mask_mode ? rgn_prot : tbl_prot;
    assign mem_wr_en = cpu_wr && !seg_prot;
    assign viol      = cpu_wr && seg_prot && trap_mode;

    segwp_report #(.IDX_W(IDX_W)) u_report (
        .clk      (clk),
        .rst_n    (rst_n),
        .viol     (viol),
        .viol_idx (seg_idx),
        .clr      (clr),
        .flag     (flag),
        .irq      (irq),
        .seg_rec  (seg_rec)
    );

    always_comb begin
        reg_rdata = '0;
        if (reg_addr == REG_AW'(REG_CTRL)) begin
            reg_rdata[0] = trap_mode;
            reg_rdata[1] = mask_mode;
        end else if (reg_addr == REG_AW'(REG_REGION)) begin
            reg_rdata[IDX_W-1:0]     = base_q;
            reg_rdata[FIELD_HI +: KW] = k_q;
        end else if (reg_addr == REG_AW'(REG_STATUS)) begin
            reg_rdata[0]                 = flag;
            reg_rdata[FIELD_HI +: IDX_W] = seg_rec;
        end else if (reg_addr >= REG_AW'(REG_TABLE0)) begin
            reg_rdata = tbl_rd;
        end
    end
endmodule

// File: rtl/seg_write_guard_chk.sv
module seg_write_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic supervisor,
    input logic cpu_wr,
    input logic mem_wr_en,
    input logic reg_we,
    input logic irq,
    input logic seg_prot,
    input logic trap_mode,
    input logic mask_mode,
    input logic clr
);
    AST_BLOCKED_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && seg_prot |-> !mem_wr_en);                          // R3
    AST_OPEN_PASSES: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_wr && !seg_prot |-> mem_wr_en);                          // R3
    AST_STROBE_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        mem_wr_en |-> cpu_wr);                                       // R3
    AST_TRAP_RAISES: assert property (@(posedge clk) disable iff (!rst_n)
        trap_mode && cpu_wr && seg_prot |=> irq);                    // R5
    AST_SILENT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !trap_mode && !irq |=> !irq);                                // R4
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !clr |=> irq);                                        // R6
    AST_USER_CFG_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we && !supervisor |=> $stable(trap_mode) && $stable(mask_mode)); // R8
endmodule

bind seg_write_guard seg_write_guard_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .supervisor (supervisor),
    .cpu_wr     (cpu_wr),
    .mem_wr_en  (mem_wr_en),
    .reg_we     (reg_we),
    .irq        (irq),
    .seg_prot   (seg_prot),
    .trap_mode  (trap_mode),
    .mask_mode  (mask_mode),
    .clr        (clr)
);

// File: tb/sim_seg_write_guard.sv
`timescale 1ns/1ps
module sim_seg_write_guard;
    localparam int SEL_WR  = 0;
    localparam int SEL_IRQ = 1;
    localparam int SEL_RD  = 2;

    typedef struct {
        int          sel;
        logic [31:0] exp;
        string       req;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        supervisor = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [21:0] cpu_addr = '0;
    logic        mem_wr_en;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        irq;

    int    checks = 0;
    int    failures = 0;
    bit    done = 0;
    item_t sb[$];
    event  ev;

    always #5 clk = ~clk;

    seg_write_guard u0 (
        .clk(clk), .rst_n(rst_n), .supervisor(supervisor),
        .cpu_wr(cpu_wr), .cpu_addr(cpu_addr), .mem_wr_en(mem_wr_en),
        .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    always begin
        @(ev);
        while (sb.size() > 0) begin
            item_t it;
            logic [31:0] act;
            it = sb.pop_front();
            case (it.sel)
                SEL_WR:  act = {31'b0, mem_wr_en};
                SEL_IRQ: act = {31'b0, irq};
                default: act = reg_rdata;
            endcase
            checks++;
            if (act !== it.exp) begin
                failures++;
                $display("FAIL %s actual=%0h expected=%0h", it.req, act, it.exp);
            end
        end
    end

    task automatic push(int sel, logic [31:0] exp, string req);
        item_t it;
        #1;
        it.sel = sel; it.exp = exp; it.req = req;
        sb.push_back(it);
        -> ev;
    endtask

    task automatic tick();
        @(posedge clk); #2;
    endtask

    task automatic cpu_write(int seg, bit exp_en, string req);
        cpu_wr = 1'b1;
        cpu_addr = {6'(seg), 16'h0ABC};
        push(SEL_WR, {31'b0, exp_en}, req);
        tick();
        cpu_wr = 1'b0;
    endtask

    task automatic reg_write(int addr, logic [31:0] data, bit sup);
        reg_we = 1'b1; supervisor = sup;
        reg_addr = 3'(addr); reg_wdata = data;
        tick();
        reg_we = 1'b0; supervisor = 1'b0;
    endtask

    task automatic expect_read(int addr, logic [31:0] exp, string req);
        reg_addr = 3'(addr);
        push(SEL_RD, exp, req);
        tick();
    endtask

    task automatic expect_irq(bit exp, string req);
        push(SEL_IRQ, {31'b0, exp}, req);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        tick();
        // R1: reset state
        expect_irq(0, "R1");
        expect_read(0, 32'h1, "R1");
        expect_read(2, 32'h0, "R1");
        cpu_write(5, 1, "R1");
        cpu_write(63, 1, "R1");
        // R8: user-mode writes ignored
        reg_write(4, 32'hFFFF_FFFF, 0);
        reg_write(0, 32'h2, 0);
        expect_read(4, 32'h0, "R8");
        expect_read(0, 32'h1, "R8");
        cpu_write(0, 1, "R8");
        // R2/R9: non-contiguous bitmap
        reg_write(4, 32'h28, 1);
        reg_write(5, 32'h100, 1);
        expect_read(4, 32'h28, "R9");
        expect_read(5, 32'h100, "R9");
        expect_read(3, 32'h0, "R9");
        // R3/R5: trapped violation
        cpu_write(3, 0, "R3");
        expect_irq(1, "R5");
        expect_read(2, 32'h301, "R5");
        cpu_write(4, 1, "R2");
        cpu_write(5, 0, "R2");
        cpu_write(40, 0, "R2");
        cpu_write(41, 1, "R2");
        expect_read(2, 32'h301, "R6");
        // R8: user clear ignored; R6: writing 0 does nothing
        reg_write(2, 32'h1, 0);
        expect_irq(1, "R8");
        reg_write(2, 32'h0, 1);
        expect_irq(1, "R6");
        reg_write(2, 32'h1, 1);
        expect_irq(0, "R6");
        tick();
        // R6: violation in the clear cycle wins
        cpu_write(40, 0, "R6");
        cpu_wr = 1'b1; cpu_addr = {6'd5, 16'h0};
        reg_we = 1'b1; supervisor = 1'b1; reg_addr = 3'd2; reg_wdata = 32'h1;
        tick();
        cpu_wr = 1'b0; reg_we = 1'b0; supervisor = 1'b0;
        expect_irq(1, "R6");
        expect_read(2, 32'h501, "R6");
        reg_write(2, 32'h1, 1);
        expect_irq(0, "R6");
        tick();
        // R4: silent policy
        reg_write(0, 32'h0, 1);
        expect_read(0, 32'h0, "R4");
        cpu_write(5, 0, "R4");
        expect_irq(0, "R4");
        expect_read(2, 32'h500, "R4");
        // R7: aligned region, base 16, k=2
        reg_write(1, 32'h210, 1);
        reg_write(0, 32'h2, 1);
        expect_read(1, 32'h210, "R9");
        cpu_write(15, 1, "R7");
        cpu_write(16, 0, "R7");
        cpu_write(19, 0, "R7");
        cpu_write(20, 1, "R7");
        cpu_write(3, 1, "R7");
        // R7: k=0 single segment
        reg_write(1, 32'h7, 1);
        cpu_write(7, 0, "R7");
        cpu_write(6, 1, "R7");
        cpu_write(8, 1, "R7");
        // R7: k=6 and k=7 whole space
        reg_write(1, 32'h600, 1);
        cpu_write(0, 0, "R7");
        cpu_write(63, 0, "R7");
        reg_write(1, 32'h72A, 1);
        cpu_write(33, 0, "R7");
        // R5: trap in region mode
        reg_write(0, 32'h3, 1);
        cpu_write(33, 0, "R5");
        expect_irq(1, "R5");
        expect_read(2, 32'h2101, "R5");
        tick();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule